// File: doc/BRIEF.md
# Two-Bank Interrupt Request Controller

This block gathers 32 interrupt request lines and turns them into two request outputs, one for a normal interrupt class and one for a fast interrupt class. Each class has its own bank of registers behind a plain 32-bit register port, with address, write enable, write data and combinational read data. Inside a bank, every line can be set to edge or level capture, with a rising or falling sense. Each line has an enable bit and a write-one-to-clear acknowledge. The bank's request output is high while any enabled line is pending.

The inputs first pass through a two-flop synchroniser, which both banks share. Software reads a bank's status word, services the set bits from the lowest-numbered one upward, and then acknowledges the edge-captured ones. The two banks hold the same six registers. The second bank's registers sit 0x20 above the first bank's.

Top module: `dual_bank_intc`

## Requirements
- R1: While reset is held and after it is released, every readable register of both banks reads 0 and both request outputs are low. Reset is synchronous and active low.
- R2: The source word (bank offset 0x00) returns the synchronised input lines. It shows a change of the inputs two clock edges after the change. Writes to it are ignored.
- R3: Byte-address map per bank: 0x00 source, 0x04 enable, 0x08 acknowledge, 0x0C trigger mode, 0x10 sense, 0x14 status. Bit 5 of the address selects the fast bank, which gives offsets 0x20 to 0x34. Enable, mode and sense read back what was written. The acknowledge register reads 0.
- R4: Enable bit n set to 1 lets line n reach status and the request output. A 0 keeps it out. All enable bits are 0 after reset.
- R5: With mode bit n = 1 (edge), line n becomes pending on the third clock edge after the input moves to its active value. Sense bit 1 selects a rising edge and sense bit 0 a falling edge. The pending bit then stays set when the input returns to idle.
- R6: With mode bit n = 0 (level), pending bit n follows the input at the active value (sense 1 = high, sense 0 = low), with the same three-edge latency. An acknowledge write leaves it unchanged.
- R7: A write to the acknowledge register clears each edge-captured pending bit whose data bit is 1, from the write edge on. Data bits of 0 change nothing.
- R8: When a new edge on a line is captured in the same cycle as an acknowledge of that line, the line stays pending. Other lines acknowledged in that write are still cleared.
- R9: Status equals pending AND enable, and follows an enable write at once. A pending bit that is disabled stays latched and shows again once it is re-enabled.
- R10: Each request output is the OR of its bank's status bits, registered, so it follows status one clock edge later.
- R11: Reads of unmapped addresses return 0 and writes to them change nothing. Unmapped addresses are offsets 0x18/0x1C/0x38/0x3C, any address with bit 0, 1, 6 or 7 set, and status (0x14/0x34) as a write target.
- R12: The two banks are independent. Writes to one bank do not change the other bank's registers or request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines_i | input | 32 | Asynchronous interrupt request lines |
| bus_addr_i | input | 8 | Register byte address |
| bus_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| irq_req_o | output | 1 | Normal-bank combined request |
| fiq_req_o | output | 1 | Fast-bank combined request |

## Verification
An input change reaches the source word after two edges and a pending bit after three, and the request output follows one edge after that. The bench changes inputs on a falling edge and counts edges from there. It checks that status is still clear after two edges, set after three, and that the request is still low at that point and high one edge later. Register writes take effect at the edge inside the write task. Status is sampled on the falling edge that follows that edge, and the request output is sampled one edge after it. The edge-versus-acknowledge race is built by issuing the acknowledge on the same third edge at which the capture lands.

// File: rtl/intc_pkg.sv
// Shared definitions for the two-bank interrupt controller.
// Assumes a byte-addressed register port with word-aligned registers.
package intc_pkg;
    localparam int unsigned REG_IDX_W = 3;

    // Register slot inside one bank (address bits [4:2]).
    typedef enum logic [REG_IDX_W-1:0] {
        IDX_SRC  = 3'd0,
        IDX_MASK = 3'd1,
        IDX_CLR  = 3'd2,
        IDX_MODE = 3'd3,
        IDX_POL  = 3'd4,
        IDX_STAT = 3'd5
    } reg_idx_e;

    // Decoded write strobes towards one bank.
    typedef struct packed {
        logic mask;
        logic clr;
        logic mode;
        logic pol;
    } bank_wr_t;
endpackage

// File: rtl/intc_sync.sv
// Multi-stage synchroniser for a vector of asynchronous request lines.
// Assumes each line is a slow level or a pulse wider than one clock period.
module intc_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw lines through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/intc_trigger.sv
// Per-line capture of interrupt requests: edge-latched or level-following.
// Assumes sync_i is already synchronised. clr_i is the gated acknowledge vector.
module intc_trigger #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] mode_i,   // 1 = edge, 0 = level
    input  logic [WIDTH-1:0] pol_i,    // 1 = rising/high, 0 = falling/low
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] pend_o
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] pend_d;
    logic [WIDTH-1:0] active_v;
    logic [WIDTH-1:0] edge_v;

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        // Line sits at its active value.
        assign active_v[g] = (sync_i[g] == pol_i[g]);
        // Transition into the active value since the previous cycle.
        assign edge_v[g]   = active_v[g] & (prev_q[g] != pol_i[g]);
        // Next pending: a new edge outranks an acknowledge; level mode tracks the input.
        assign pend_d[g]   = mode_i[g] ? (edge_v[g] | (pend_q[g] & ~clr_i[g]))
                                       : active_v[g];
    end

    // Hold the last sampled line values and the pending latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= sync_i;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & mode_i & ~edge_v)) |=> ((pend_o & $past(clr_i & mode_i & ~edge_v)) == '0));
    // R8
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(edge_v & mode_i)) |=> ((pend_o & $past(edge_v & mode_i)) == $past(edge_v & mode_i)));
    // R5
    edge_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_o & mode_i & ~clr_i)) |=>
        ((pend_o & $past(pend_o & mode_i & ~clr_i)) == $past(pend_o & mode_i & ~clr_i)));
    // R6
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend_o ^ ~$past(sync_i ^ pol_i)) & $past(~mode_i)) == '0));
endmodule

// File: rtl/intc_bank.sv
// One register bank: enable, trigger mode, sense, acknowledge, status and request.
// Assumes write strobes are already decoded and the input lines already synchronised.
module intc_bank
    import intc_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  bank_wr_t         wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] mask_o,
    output logic [WIDTH-1:0] mode_o,
    output logic [WIDTH-1:0] pol_o,
    output logic [WIDTH-1:0] status_o,
    output logic             req_o
);
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] mode_q;
    logic [WIDTH-1:0] pol_q;
    logic [WIDTH-1:0] clr_v;
    logic [WIDTH-1:0] pend_v;
    logic             req_q;

    // Configuration registers, loaded by their write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            mode_q <= '0;
            pol_q  <= '0;
        end else begin
            if (wr_i.mask) mask_q <= wdata_i;
            if (wr_i.mode) mode_q <= wdata_i;
            if (wr_i.pol)  pol_q  <= wdata_i;
        end
    end

    // Acknowledge vector is live only during a write to the acknowledge slot.
    assign clr_v = wr_i.clr ? wdata_i : '0;

    intc_trigger #(.WIDTH(WIDTH)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .mode_i (mode_q),
        .pol_i  (pol_q),
        .clr_i  (clr_v),
        .pend_o (pend_v)
    );

    assign status_o = pend_v & mask_q;

    // Register the combined request of all enabled pending lines.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |status_o;
    end

    assign req_o  = req_q;
    assign mask_o = mask_q;
    assign mode_o = mode_q;
    assign pol_o  = pol_q;

    // R10
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req_o == $past(|(pend_v & mask_q))));
    // R12
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i.mask |=> $stable(mask_q));
endmodule

// File: rtl/dual_bank_intc.sv
// Two-bank interrupt controller top: synchroniser, address decode, banks, read mux.
// Assumes a byte-addressed port; bit 5 selects the bank and bits [4:2] the register.
module dual_bank_intc
    import intc_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic                 bus_we_i,
    input  logic [NUM_LINES-1:0] bus_wdata_i,
    output logic [NUM_LINES-1:0] bus_rdata_o,
    output logic                 irq_req_o,
    output logic                 fiq_req_o
);
    localparam int unsigned NUM_BANKS = 2;
    localparam int unsigned BANK_BIT  = 5;
    localparam int unsigned IDX_LO    = 2;
    localparam int unsigned HIGH_LO   = BANK_BIT + 1;

    logic [NUM_LINES-1:0] sync_v;
    logic [NUM_LINES-1:0] mask_a   [NUM_BANKS];
    logic [NUM_LINES-1:0] mode_a   [NUM_BANKS];
    logic [NUM_LINES-1:0] pol_a    [NUM_BANKS];
    logic [NUM_LINES-1:0] status_a [NUM_BANKS];
    logic                 req_a    [NUM_BANKS];
    reg_idx_e             idx;
    logic                 bank_sel;
    logic                 addr_ok;

    intc_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_lines_i),
        .sync_o  (sync_v)
    );

    assign idx      = reg_idx_e'(bus_addr_i[BANK_BIT-1:IDX_LO]);
    assign bank_sel = bus_addr_i[BANK_BIT];

    // Decide whether the address hits a defined register slot.
    always_comb begin
        addr_ok = (bus_addr_i[IDX_LO-1:0] == '0) &&
                  (bus_addr_i[ADDR_W-1:HIGH_LO] == '0) &&
                  (bus_addr_i[BANK_BIT-1:IDX_LO] <= 3'(IDX_STAT));
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_wr_t wr_s;
        logic     hit;

        assign hit = bus_we_i && addr_ok && (bank_sel == b[0]);

        // Per-bank write strobes from the register slot index.
        always_comb begin
            wr_s.mask = hit && (idx == IDX_MASK);
            wr_s.clr  = hit && (idx == IDX_CLR);
            wr_s.mode = hit && (idx == IDX_MODE);
            wr_s.pol  = hit && (idx == IDX_POL);
        end

        intc_bank #(.WIDTH(NUM_LINES)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (sync_v),
            .wr_i     (wr_s),
            .wdata_i  (bus_wdata_i),
            .mask_o   (mask_a[b]),
            .mode_o   (mode_a[b]),
            .pol_o    (pol_a[b]),
            .status_o (status_a[b]),
            .req_o    (req_a[b])
        );
    end

    // Select the addressed register word, zero for unmapped slots.
    always_comb begin
        bus_rdata_o = '0;
        if (addr_ok) begin
            case (idx)
                IDX_SRC:  bus_rdata_o = sync_v;
                IDX_MASK: bus_rdata_o = mask_a[bank_sel];
                IDX_MODE: bus_rdata_o = mode_a[bank_sel];
                IDX_POL:  bus_rdata_o = pol_a[bank_sel];
                IDX_STAT: bus_rdata_o = status_a[bank_sel];
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    assign irq_req_o = req_a[0];
    assign fiq_req_o = req_a[1];

    // R11
    misalign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i[1:0] != 2'b00) |-> (bus_rdata_o == '0));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_req_o && !fiq_req_o));
endmodule

// File: tb/sim_dual_bank_intc.sv
`timescale 1ns/1ps
module sim_dual_bank_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_req, fiq_req;
    int          vecs = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dual_bank_intc u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
        .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_req_o(irq_req), .fiq_req_o(fiq_req)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a; we = 1'b0;
        #1;
        chk(rdata === exp, tag, rdata, exp);
    endtask

    task automatic chk_req(input logic ei, input logic ef, input string tag);
        chk({irq_req, fiq_req} === {ei, ef}, tag, {30'd0, irq_req, fiq_req}, {30'd0, ei, ef});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; vecs++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] idle;
        logic [31:0] act;
        // R1: reset state
        tick(3);
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 6; r++)
                chk_rd(8'(b*32 + r*4), 32'h0, "R1 reset register");
        chk_req(1'b0, 1'b0, "R1 reset requests");
        rst_n = 1'b1;
        tick(1);
        chk_req(1'b0, 1'b0, "R1 after release");
        chk_rd(8'h24, 32'h0, "R1 fast enable after release");

        // R3 / R12: readback sweep over the writable slots of both banks
        for (int b = 0; b < 2; b++)
            for (int r = 1; r < 5; r++)
                if (r != 2) wr(8'(b*32 + r*4), 32'h1234_0000 | 32'(b*16 + r));
        for (int b = 0; b < 2; b++) begin
            for (int r = 1; r < 5; r++)
                chk_rd(8'(b*32 + r*4), (r == 2) ? 32'h0 : (32'h1234_0000 | 32'(b*16 + r)),
                       "R3 R12 readback");
        end

        // R2: source latency and write-ignore
        lines = 32'hC0DE_0001;
        tick(1);
        chk_rd(8'h00, 32'h0, "R2 source before second edge");
        tick(1);
        chk_rd(8'h00, 32'hC0DE_0001, "R2 source after two edges");
        chk_rd(8'h20, 32'hC0DE_0001, "R2 source fast bank");
        wr(8'h00, 32'hFFFF_FFFF);
        chk_rd(8'h00, 32'hC0DE_0001, "R2 source write ignored");

        // Edge sweep on the normal bank; upper half rising, lower half falling
        idle = 32'h0000_FFFF;
        wr(8'h24, 32'h0);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_0000);
        lines = idle;
        tick(4);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        chk_rd(8'h14, 32'h0, "R7 clear-all leaves nothing pending");
        tick(1);
        for (int i = 0; i < 32; i++) begin
            act = idle ^ (32'h1 << i);
            lines = act;
            tick(2);
            chk_rd(8'h14, 32'h0, "R5 not pending before third edge");
            tick(1);
            chk_rd(8'h14, 32'h1 << i, "R5 pending on third edge");
            chk_req(1'b0, 1'b0, "R10 request not yet");
            tick(1);
            chk_req(1'b1, 1'b0, "R10 request one edge later, R12 fast quiet");
            lines = idle;
            tick(3);
            chk_rd(8'h14, 32'h1 << i, "R5 held after input idle");
            wr(8'h08, 32'h0);
            chk_rd(8'h14, 32'h1 << i, "R7 zero bits no effect");
            wr(8'h08, 32'h1 << i);
            chk_rd(8'h14, 32'h0, "R7 acknowledge clears");
            chk_req(1'b1, 1'b0, "R10 request lags clear");
            tick(1);
            chk_req(1'b0, 1'b0, "R10 request drops");
        end

        // Level sweep on the fast bank; odd lines active high, even lines active low
        wr(8'h04, 32'h0);
        idle = 32'h5555_5555;
        wr(8'h2C, 32'h0);
        wr(8'h30, 32'hAAAA_AAAA);
        lines = idle;
        tick(3);
        wr(8'h24, 32'hFFFF_FFFF);
        chk_rd(8'h34, 32'h0, "R6 idle level not pending");
        for (int i = 0; i < 32; i++) begin
            lines = idle ^ (32'h1 << i);
            tick(2);
            chk_rd(8'h34, 32'h0, "R6 level latency");
            tick(1);
            chk_rd(8'h34, 32'h1 << i, "R6 level pending");
            wr(8'h28, 32'hFFFF_FFFF);
            chk_rd(8'h34, 32'h1 << i, "R6 acknowledge ignored in level mode");
            chk_req(1'b0, 1'b1, "R10 fast request, R12 normal quiet");
            lines = idle;
            tick(3);
            chk_rd(8'h34, 32'h0, "R6 level follows input back");
            tick(1);
            chk_req(1'b0, 1'b0, "R10 fast request drops");
        end

        // R8: edge and acknowledge in the same cycle (normal bank edge config kept)
        wr(8'h24, 32'h0);
        idle = 32'h0000_FFFF;
        lines = idle;
        tick(4);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        lines = idle ^ 32'h40;
        tick(3);
        lines = idle;
        tick(3);
        chk_rd(8'h14, 32'h40, "R8 setup line 6 pending");
        lines = idle ^ 32'h20;
        tick(2);
        wr(8'h08, 32'h60);
        chk_rd(8'h14, 32'h20, "R8 new edge wins, other line cleared");
        lines = idle;
        wr(8'h08, 32'h20);
        chk_rd(8'h14, 32'h0, "R8 later acknowledge clears");

        // R9: exhaustive enable patterns over four pending lines
        lines = idle ^ 32'hF;
        tick(3);
        lines = idle;
        tick(3);
        for (int m = 0; m < 16; m++) begin
            wr(8'h04, 32'(m));
            chk_rd(8'h14, 32'(m), "R9 status is pending and enable");
            tick(1);
            chk_req(m != 0, 1'b0, "R9 R10 request from enabled lines");
        end
        wr(8'h04, 32'h0);
        chk_rd(8'h14, 32'h0, "R4 disabled lines hidden");
        wr(8'h04, 32'hF);
        chk_rd(8'h14, 32'hF, "R9 latched lines return when enabled");

        // R11: unmapped reads and writes
        chk_rd(8'h18, 32'h0, "R11 read 0x18");
        chk_rd(8'h1C, 32'h0, "R11 read 0x1C");
        chk_rd(8'h38, 32'h0, "R11 read 0x38");
        chk_rd(8'h44, 32'h0, "R11 read 0x44");
        chk_rd(8'h05, 32'h0, "R11 read misaligned");
        chk_rd(8'h84, 32'h0, "R11 read high alias");
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h64, 32'hFFFF_FFFF);
        wr(8'h05, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        chk_rd(8'h04, 32'hF, "R11 normal enable untouched");
        chk_rd(8'h24, 32'h0, "R11 fast enable untouched");
        chk_rd(8'h0C, 32'hFFFF_FFFF, "R11 normal mode untouched");
        chk_rd(8'h14, 32'hF, "R11 status write ignored");
        chk_rd(8'h30, 32'hAAAA_AAAA, "R12 fast sense untouched");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule